// File: doc/BRIEF.md
# Accumulator and Link Datapath

This block holds the working register of a single-accumulator machine together with the one-bit link register that extends it. Each clock cycle the instruction sequencer raises at most one operation strobe. The block then updates the accumulator, the link, or both. It can do bitwise AND, addition with carry into the link, loading a memory operand, loading an input character into the low byte, complementing, incrementing and clearing. It can also rotate the accumulator and link together as one ring of DATA_W+1 bits in either direction, and clear or complement the link on its own.

Instruction decoding and memory access happen elsewhere. The operand word and the input character arrive as plain data inputs. Three status flags are derived from the current register contents so that the sequencer can take conditional skips: accumulator zero, accumulator negative, and link clear. When no strobe is raised, the block holds its state.

Top module: `acc_link_unit`

## Requirements
- R1: While rst_n is low, the accumulator and the link are both cleared to 0 at each rising clock edge.
- R2: When and_en is high, the accumulator takes the bitwise AND of itself with operand_i at the next edge, and the link is unchanged.
- R3: When add_en is high, the accumulator takes the low DATA_W bits of accumulator plus operand_i, and the link takes the carry out of bit DATA_W-1.
- R4: When load_en is high, the accumulator takes operand_i, and the link is unchanged.
- R5: When char_en is high, bits CHAR_W-1..0 of the accumulator take char_i, the upper bits keep their value, and the link is unchanged.
- R6: When inv_en is high, every accumulator bit is inverted, and the link is unchanged.
- R7: When rotr_en is high, the accumulator shifts right by one, the old link enters the most significant bit, and the old bit 0 enters the link.
- R8: When rotl_en is high, the accumulator shifts left by one, the old link enters bit 0, and the old most significant bit enters the link.
- R9: When inc_en is high, the accumulator increases by one modulo 2^DATA_W (all ones wraps to zero), and the link is unchanged.
- R10: When clr_en is high, the accumulator becomes 0, and the link is unchanged.
- R11: link_clr_en sets the link to 0 and link_inv_en inverts it. Neither one changes the accumulator.
- R12: In a cycle with no strobe raised, the accumulator and the link hold their values.
- R13: acc_zero_o is 1 exactly when all accumulator bits are 0, acc_neg_o equals the accumulator's most significant bit, and link_zero_o is 1 exactly when the link is 0. All three reflect the current register contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| and_en | input | 1 | Strobe: AND operand into accumulator |
| add_en | input | 1 | Strobe: add operand, carry to link |
| load_en | input | 1 | Strobe: copy operand into accumulator |
| char_en | input | 1 | Strobe: load input character into low byte |
| inv_en | input | 1 | Strobe: complement accumulator |
| rotr_en | input | 1 | Strobe: rotate link and accumulator right |
| rotl_en | input | 1 | Strobe: rotate link and accumulator left |
| inc_en | input | 1 | Strobe: increment accumulator |
| clr_en | input | 1 | Strobe: clear accumulator |
| link_clr_en | input | 1 | Strobe: clear link |
| link_inv_en | input | 1 | Strobe: complement link |
| operand_i | input | DATA_W | Memory operand word |
| char_i | input | CHAR_W | Input character |
| acc_o | output | DATA_W | Accumulator contents |
| link_o | output | 1 | Link contents |
| acc_zero_o | output | 1 | Accumulator is all zeros |
| acc_neg_o | output | 1 | Accumulator most significant bit |
| link_zero_o | output | 1 | Link is zero |

## Verification
The bench goes after the places where the ring and the carry cross the word boundary:
- Adding all-ones to a nonzero value must set the link. A design that drops the carry leaves the link stale.
- Rotating with the link set must move that 1 into the opposite end of the word. Swapping the entry and exit ends breaks the rotate into a plain shift.
- Incrementing all-ones must wrap to zero with the link untouched. A design that reuses the adder's carry for increment corrupts the link.
- Loading a character must leave the upper byte alone. A design that zero-extends the character wipes it.

// File: rtl/acc_link_pkg.sv
// Package: shared operation encoding for the accumulator datapath.
// Assumes the sequencer raises at most one strobe per cycle.
package acc_link_pkg;

    localparam int unsigned OP_COUNT = 11;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_AND      = 4'd1,
        OP_ADD      = 4'd2,
        OP_LOAD     = 4'd3,
        OP_CHAR     = 4'd4,
        OP_INV      = 4'd5,
        OP_ROTR     = 4'd6,
        OP_ROTL     = 4'd7,
        OP_INC      = 4'd8,
        OP_CLR      = 4'd9,
        OP_LINK_CLR = 4'd10,
        OP_LINK_INV = 4'd11
    } acc_op_e;

endpackage

// File: rtl/acc_op_encode.sv
// Module: turns the strobe vector into one operation code.
// Assumes at most one strobe is high; if several are, the lowest index wins.
module acc_op_encode
    import acc_link_pkg::*;
(
    input  logic [OP_COUNT-1:0] strobe_i,
    output acc_op_e             op_o
);

    // Priority scan from the highest index down, so the lowest set bit is kept.
    always_comb begin
        op_o = OP_NONE;
        for (int idx = OP_COUNT - 1; idx >= 0; idx--) begin
            if (strobe_i[idx]) begin
                op_o = acc_op_e'(idx + 1);
            end
        end
    end

endmodule

// File: rtl/acc_logic.sv
// Module: next-state logic for all non-rotating operations.
// Assumes CHAR_W < DATA_W. It holds both registers for ops it does not own.
module acc_logic
    import acc_link_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8
)(
    input  acc_op_e             op_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic                link_i,
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [CHAR_W-1:0]   char_i,
    output logic [DATA_W-1:0]   acc_nxt_o,
    output logic                link_nxt_o
);

    localparam int unsigned HI_W = DATA_W - CHAR_W;

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] inc_val;

    // Adder with carry out, and a separate incrementer.
    always_comb begin
        sum_ext = {1'b0, acc_i} + {1'b0, operand_i};
        inc_val = acc_i + {{(DATA_W-1){1'b0}}, 1'b1};
    end

    // Select the result for the current operation.
    always_comb begin
        acc_nxt_o  = acc_i;
        link_nxt_o = link_i;
        unique case (op_i)
            OP_AND:      acc_nxt_o = acc_i & operand_i;
            OP_ADD: begin
                acc_nxt_o  = sum_ext[DATA_W-1:0];
                link_nxt_o = sum_ext[DATA_W];
            end
            OP_LOAD:     acc_nxt_o = operand_i;
            OP_CHAR:     acc_nxt_o = {acc_i[DATA_W-1 -: HI_W], char_i};
            OP_INV:      acc_nxt_o = ~acc_i;
            OP_INC:      acc_nxt_o = inc_val;
            OP_CLR:      acc_nxt_o = '0;
            OP_LINK_CLR: link_nxt_o = 1'b0;
            OP_LINK_INV: link_nxt_o = ~link_i;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_rotate.sv
// Module: rotates the link and accumulator as one ring of DATA_W+1 bits.
// It raises hit_o only for the two rotate operations.
module acc_rotate
    import acc_link_pkg::*;
#(
    parameter int unsigned DATA_W = 16
)(
    input  acc_op_e             op_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic                link_i,
    output logic [DATA_W-1:0]   acc_nxt_o,
    output logic                link_nxt_o,
    output logic                hit_o
);

    logic [DATA_W:0] ring;

    // Ring with the link above the accumulator's top bit.
    always_comb ring = {link_i, acc_i};

    // Rotate the ring by one place in the requested direction.
    always_comb begin
        hit_o      = 1'b0;
        acc_nxt_o  = acc_i;
        link_nxt_o = link_i;
        if (op_i == OP_ROTR) begin
            hit_o                     = 1'b1;
            {link_nxt_o, acc_nxt_o}   = {ring[0], ring[DATA_W:1]};
        end else if (op_i == OP_ROTL) begin
            hit_o                     = 1'b1;
            {link_nxt_o, acc_nxt_o}   = {ring[DATA_W-1:0], ring[DATA_W]};
        end
    end

endmodule

// File: rtl/acc_status.sv
// Module: condition flags derived from the current register contents.
module acc_status #(
    parameter int unsigned DATA_W = 16
)(
    input  logic [DATA_W-1:0] acc_i,
    input  logic              link_i,
    output logic              zero_o,
    output logic              neg_o,
    output logic              link_zero_o
);

    // Reduce the word to the three skip conditions.
    always_comb begin
        zero_o      = ~(|acc_i);
        neg_o       = acc_i[DATA_W-1];
        link_zero_o = ~link_i;
    end

endmodule

// File: rtl/acc_link_unit.sv
// Module: accumulator and link registers with their operation datapath.
// Assumes one strobe at most per cycle and a synchronous active-low reset.
module acc_link_unit
    import acc_link_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                and_en,
    input  logic                add_en,
    input  logic                load_en,
    input  logic                char_en,
    input  logic                inv_en,
    input  logic                rotr_en,
    input  logic                rotl_en,
    input  logic                inc_en,
    input  logic                clr_en,
    input  logic                link_clr_en,
    input  logic                link_inv_en,
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [CHAR_W-1:0]   char_i,
    output logic [DATA_W-1:0]   acc_o,
    output logic                link_o,
    output logic                acc_zero_o,
    output logic                acc_neg_o,
    output logic                link_zero_o
);

    logic [OP_COUNT-1:0] strobes;
    acc_op_e             op;
    logic [DATA_W-1:0]   acc_q, log_acc, rot_acc, acc_d;
    logic                link_q, log_link, rot_link, link_d, rot_hit;

    // Gather the strobes in encoding order.
    always_comb strobes = {link_inv_en, link_clr_en, clr_en, inc_en, rotl_en,
                           rotr_en, inv_en, char_en, load_en, add_en, and_en};

    acc_op_encode enc_i (
        .strobe_i (strobes),
        .op_o     (op)
    );

    acc_logic #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) logic_i (
        .op_i       (op),
        .acc_i      (acc_q),
        .link_i     (link_q),
        .operand_i  (operand_i),
        .char_i     (char_i),
        .acc_nxt_o  (log_acc),
        .link_nxt_o (log_link)
    );

    acc_rotate #(.DATA_W(DATA_W)) rot_i (
        .op_i       (op),
        .acc_i      (acc_q),
        .link_i     (link_q),
        .acc_nxt_o  (rot_acc),
        .link_nxt_o (rot_link),
        .hit_o      (rot_hit)
    );

    // Take the rotator's result when it owns the operation.
    always_comb begin
        acc_d  = rot_hit ? rot_acc  : log_acc;
        link_d = rot_hit ? rot_link : log_link;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            link_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            link_q <= link_d;
        end
    end

    acc_status #(.DATA_W(DATA_W)) stat_i (
        .acc_i       (acc_q),
        .link_i      (link_q),
        .zero_o      (acc_zero_o),
        .neg_o       (acc_neg_o),
        .link_zero_o (link_zero_o)
    );

    // Drive the register outputs.
    always_comb begin
        acc_o  = acc_q;
        link_o = link_q;
    end

endmodule

// File: rtl/acc_link_checker.sv
// Module: property checks on the accumulator unit's ports, attached by bind.
module acc_link_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic              and_en,
    input logic              add_en,
    input logic              load_en,
    input logic              char_en,
    input logic              inv_en,
    input logic              rotr_en,
    input logic              rotl_en,
    input logic              inc_en,
    input logic              clr_en,
    input logic              link_clr_en,
    input logic              link_inv_en,
    input logic [DATA_W-1:0] operand_i,
    input logic [CHAR_W-1:0] char_i,
    input logic [DATA_W-1:0] acc_o,
    input logic              link_o,
    input logic              acc_zero_o,
    input logic              acc_neg_o,
    input logic              link_zero_o
);

    logic [10:0] strb;
    always_comb strb = {and_en, add_en, load_en, char_en, inv_en, rotr_en,
                        rotl_en, inc_en, clr_en, link_clr_en, link_inv_en};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0) && !link_o);

    // R2
    and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        and_en |=> acc_o == ($past(acc_o) & $past(operand_i)) && $stable(link_o));

    // R3
    add_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> {link_o, acc_o} == {1'b0, $past(acc_o)} + {1'b0, $past(operand_i)});

    // R4
    load_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_o == $past(operand_i) && $stable(link_o));

    // R5
    char_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_en |=> acc_o[CHAR_W-1:0] == $past(char_i)
                    && $stable(acc_o[DATA_W-1:CHAR_W]) && $stable(link_o));

    // R6
    inv_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> acc_o == ~$past(acc_o) && $stable(link_o));

    // R7
    rotr_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rotr_en |=> acc_o == {$past(link_o), $past(acc_o[DATA_W-1:1])}
                    && link_o == $past(acc_o[0]));

    // R8
    rotl_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rotl_en |=> acc_o == {$past(acc_o[DATA_W-2:0]), $past(link_o)}
                    && link_o == $past(acc_o[DATA_W-1]));

    // R9
    inc_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> acc_o == $past(acc_o) + 1'b1 && $stable(link_o));

    // R10
    clr_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> acc_o == '0 && $stable(link_o));

    // R11
    link_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_clr_en |=> !link_o && $stable(acc_o));

    // R11
    link_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_inv_en |=> link_o != $past(link_o) && $stable(acc_o));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == '0) |=> $stable(acc_o) && $stable(link_o));

    // R12 (precondition of all strobe checks)
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    // R13
    flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_zero_o == (acc_o == '0) && acc_neg_o == acc_o[DATA_W-1]
        && link_zero_o == !link_o);

endmodule

bind acc_link_unit acc_link_checker #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .and_en(and_en), .add_en(add_en),
    .load_en(load_en), .char_en(char_en), .inv_en(inv_en),
    .rotr_en(rotr_en), .rotl_en(rotl_en), .inc_en(inc_en), .clr_en(clr_en),
    .link_clr_en(link_clr_en), .link_inv_en(link_inv_en),
    .operand_i(operand_i), .char_i(char_i), .acc_o(acc_o), .link_o(link_o),
    .acc_zero_o(acc_zero_o), .acc_neg_o(acc_neg_o), .link_zero_o(link_zero_o)
);

// File: tb/acc_link_unit_tb_top.sv
// Bench: a behavioural reference model compared with the outputs every clock.
module acc_link_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        and_en, add_en, load_en, char_en, inv_en, rotr_en, rotl_en;
    logic        inc_en, clr_en, link_clr_en, link_inv_en;
    logic [15:0] operand_i;
    logic [7:0]  char_i;
    logic [15:0] acc_o;
    logic        link_o, acc_zero_o, acc_neg_o, link_zero_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_acc;
    logic        m_link;

    always #5 clk = ~clk;

    acc_link_unit dut_i (
        .clk(clk), .rst_n(rst_n), .and_en(and_en), .add_en(add_en),
        .load_en(load_en), .char_en(char_en), .inv_en(inv_en),
        .rotr_en(rotr_en), .rotl_en(rotl_en), .inc_en(inc_en), .clr_en(clr_en),
        .link_clr_en(link_clr_en), .link_inv_en(link_inv_en),
        .operand_i(operand_i), .char_i(char_i), .acc_o(acc_o), .link_o(link_o),
        .acc_zero_o(acc_zero_o), .acc_neg_o(acc_neg_o), .link_zero_o(link_zero_o)
    );

    function automatic string tag_of(int op);
        case (op)
            1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
            5: return "R6";  6: return "R7";  7: return "R8";  8: return "R9";
            9: return "R10"; 10: return "R11"; 11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check_val(req, "acc", int'(acc_o), int'(m_acc));
        check_val(req, "link", int'(link_o), int'(m_link));
        check_val("R13", "zero flag", int'(acc_zero_o), (m_acc == 0) ? 1 : 0);
        check_val("R13", "neg flag", int'(acc_neg_o), int'(m_acc[15]));
        check_val("R13", "link zero flag", int'(link_zero_o), m_link ? 0 : 1);
    endtask

    task automatic set_strobes(int op);
        and_en = (op == 1); add_en = (op == 2); load_en = (op == 3);
        char_en = (op == 4); inv_en = (op == 5); rotr_en = (op == 6);
        rotl_en = (op == 7); inc_en = (op == 8); clr_en = (op == 9);
        link_clr_en = (op == 10); link_inv_en = (op == 11);
    endtask

    // Drive one operation, advance the model, compare after the edge.
    task automatic step(int op, logic [15:0] opd, logic [7:0] ch);
        int sum;
        set_strobes(op);
        operand_i = opd;
        char_i    = ch;
        case (op)
            1: m_acc = m_acc & opd;
            2: begin
                sum    = int'(m_acc) + int'(opd);
                m_acc  = sum[15:0];
                m_link = sum[16];
            end
            3: m_acc = opd;
            4: m_acc = (m_acc & 16'hFF00) | {8'h00, ch};
            5: m_acc = ~m_acc;
            6: begin
                sum    = int'(m_acc);
                m_acc  = (m_acc >> 1) | (m_link ? 16'h8000 : 16'h0000);
                m_link = sum[0];
            end
            7: begin
                sum    = int'(m_acc);
                m_acc  = (m_acc << 1) | (m_link ? 16'h0001 : 16'h0000);
                m_link = sum[15];
            end
            8: m_acc = m_acc + 16'd1;
            9: m_acc = 16'h0000;
            10: m_link = 1'b0;
            11: m_link = ~m_link;
            default: ;
        endcase
        @(negedge clk);
        compare_all(tag_of(op));
    endtask

    initial begin
        rst_n = 1'b0;
        set_strobes(0);
        operand_i = 16'h0;
        char_i    = 8'h0;
        m_acc     = 16'h0;
        m_link    = 1'b0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;

        // R4 load, R2 AND, R12 hold
        step(3, 16'hA5C3, 8'h00);
        step(1, 16'h0FF0, 8'h00);
        step(0, 16'hFFFF, 8'hFF);
        // R3 add with carry out
        step(3, 16'h8001, 8'h00);
        step(2, 16'hFFFF, 8'h00);
        step(2, 16'h0001, 8'h00);
        // R5 char keeps upper byte
        step(3, 16'h12AB, 8'h00);
        step(4, 16'h0000, 8'h7E);
        // R6 complement, R9 wrap
        step(5, 16'h0, 8'h0);
        step(3, 16'hFFFF, 8'h00);
        step(11, 16'h0, 8'h0);
        step(8, 16'h0, 8'h0);
        // R7 / R8 with link set
        step(3, 16'h0001, 8'h00);
        step(6, 16'h0, 8'h0);
        step(6, 16'h0, 8'h0);
        step(7, 16'h0, 8'h0);
        step(7, 16'h0, 8'h0);
        // R10, R11
        step(11, 16'h0, 8'h0);
        step(9, 16'h0, 8'h0);
        step(10, 16'h0, 8'h0);
        step(11, 16'h0, 8'h0);

        for (int k = 0; k < 400; k++) begin
            step(int'($urandom_range(0, 11)), 16'($urandom), 8'($urandom));
        end

        set_strobes(0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule